// File: doc/BRIEF.md
# Serial EEPROM Device Model with Three-Wire Command Port

This block models a small serial EEPROM made of 16-bit words for use inside a chip or on an FPGA. Four signals reach it: a chip select, a serial clock, serial data in, and serial data out. It runs on the system clock, and it samples the serial clock and chip select as ordinary synchronous inputs. A host that raises the chip select and clocks in an instruction can read a word, write it, erase it, fill or clear the whole array, and turn programming permission on or off.

Each instruction is a start bit, a two-bit opcode and an address, in that order. The address has `ADDR_W` bits, 6 or 8, and the array holds 2^`ADDR_W` words. The opcode that is all zeros does not name a word. In that case the top two address bits pick one of four whole-device commands.

Programming starts only after the chip select is dropped. While it runs, data out reports busy: with chip select high it reads 0 and then turns to 1 when the work is done. The busy time is a parameter counted in system clocks.

Top module: `uwire_eeprom`

## Requirements
- R1: An instruction begins at the first 1 seen on `di` at a rising `sk` edge while `cs` is high. Any 0 bits sent before that 1 are ignored.
- R2: A READ instruction has opcode `10` and is followed by the address, MSB first. After the last address bit, `dout` shows a single 0. Then comes the 16-bit word, MSB first, advancing by one bit at each rising `sk`.
- R3: A WRITE instruction has opcode `01`. The address follows, then 16 data bits MSB first. The word is stored once `cs` drops, provided programming is enabled.
- R4: An ERASE instruction has opcode `11`. It sets the addressed word to 0xFFFF and leaves every other word unchanged.
- R5: With opcode `00`, the two top address bits select the command. `10` sets every word to 0xFFFF. `01` takes 16 data bits and writes that value to every word.
- R6: Programming permission is off after reset. Opcode `00` with top address bits `11` turns it on, and opcode `00` with top address bits `00` turns it off. While it is off, a write, erase, fill or clear changes no word and starts no busy period.
- R7: With `cs` high and no instruction in progress, `dout` reads 0 while programming is busy and 1 otherwise. A single-word busy period lasts about `BUSY_CYCLES` clocks from the `cs` drop. A whole-array period lasts one clock longer per word.
- R8: Start bits are not accepted while programming is busy, so an instruction sent during that time has no effect.
- R9: Dropping `cs` at any point abandons a partly received instruction. A WRITE that is cut off during its data bits programs nothing.
- R10: `dout` is 0 whenever `cs` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | System clock |
| rst  | input  | 1 | Synchronous active-high reset |
| cs   | input  | 1 | Chip select, active high |
| sk   | input  | 1 | Serial clock; data is sampled at its rising edges |
| di   | input  | 1 | Serial instruction, address and data input |
| dout | output | 1 | Serial read data, or the ready/busy status |

## Verification
Two things can happen in the same cycle: the busy countdown running after a program, and a new start bit arriving from the host. To provoke this, the bench issues a WRITE. Then, well inside the busy window, it reselects the device and clocks in a complete ERASE to the same word. The result is judged at the ports: `dout` still reads 0 when the device is reselected, and a later READ returns the written value, not 0xFFFF. Whole-array commands are judged by how long the busy period lasts and by reading back every word.

// File: rtl/uwe_pkg.sv
package uwe_pkg;
  typedef enum logic [2:0] {
    DS_IDLE, DS_HDR, DS_DATA, DS_READ, DS_ARMED, DS_SKIP
  } dec_state_e;

  typedef enum logic [1:0] {
    PK_WORD, PK_ERASE, PK_FILL, PK_CLEAR
  } pg_kind_e;

  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_CLEAR  = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;
endpackage

// File: rtl/uwe_array.sv
module uwe_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single write port, registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    q <= mem[ra];
  end
endmodule

// File: rtl/uwe_decode.sv
module uwe_decode
  import uwe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              sk_rise,
  input  logic              di,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_q,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wen_set,
  output logic              wen_clr,
  output logic              pg_go,
  output pg_kind_e          pg_kind,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [DATA_W-1:0] pg_data,
  output logic              rd_bit,
  output logic              idle,
  output logic              reading
);
  localparam int HDR_W = ADDR_W + 2;
  localparam int CNT_W = $clog2(HDR_W + DATA_W);

  dec_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [HDR_W-2:0]  hdr;
  logic [DATA_W-1:0] sh;
  logic [1:0]        ld;

  logic [HDR_W-1:0]  hdr_full;
  logic [1:0]        op, sub;
  logic [ADDR_W-1:0] addr;
  logic              last_hdr, last_dat;

  assign hdr_full = {hdr, di};
  assign op       = hdr_full[HDR_W-1 -: 2];
  assign sub      = hdr_full[ADDR_W-1 -: 2];
  assign addr     = hdr_full[ADDR_W-1:0];
  assign last_hdr = (cnt == CNT_W'(HDR_W - 1));
  assign last_dat = (cnt == CNT_W'(DATA_W - 1));
  assign idle     = (state == DS_IDLE);
  assign reading  = (state == DS_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= DS_IDLE;
      cnt     <= '0;
      hdr     <= '0;
      sh      <= '0;
      ld      <= '0;
      rd_addr <= '0;
      wen_set <= 1'b0;
      wen_clr <= 1'b0;
      pg_go   <= 1'b0;
      pg_kind <= PK_WORD;
      pg_addr <= '0;
      pg_data <= '0;
      rd_bit  <= 1'b0;
    end else begin
      wen_set <= 1'b0;
      wen_clr <= 1'b0;
      pg_go   <= 1'b0;
      // two-cycle wait covers the registered array read
      if (ld != 2'd0) begin
        ld <= ld - 2'd1;
        if (ld == 2'd1) sh <= rd_q;
      end
      if (!cs) begin
        if (state == DS_ARMED) pg_go <= 1'b1;
        state <= DS_IDLE;
        cnt   <= '0;
      end else if (sk_rise) begin
        case (state)
          DS_IDLE: begin
            if (di && !busy) begin
              state <= DS_HDR;
              cnt   <= '0;
            end
          end
          DS_HDR: begin
            hdr <= hdr_full[HDR_W-2:0];
            cnt <= cnt + 1'b1;
            if (last_hdr) begin
              cnt     <= '0;
              pg_addr <= addr;
              pg_data <= '1;
              case (op)
                OP_READ: begin
                  rd_addr <= addr;
                  ld      <= 2'd2;
                  rd_bit  <= 1'b0;
                  state   <= DS_READ;
                end
                OP_WRITE: begin
                  pg_kind <= PK_WORD;
                  state   <= DS_DATA;
                end
                OP_ERASE: begin
                  pg_kind <= PK_ERASE;
                  state   <= DS_ARMED;
                end
                default: begin
                  case (sub)
                    SUB_UNLOCK: begin
                      wen_set <= 1'b1;
                      state   <= DS_SKIP;
                    end
                    SUB_LOCK: begin
                      wen_clr <= 1'b1;
                      state   <= DS_SKIP;
                    end
                    SUB_CLEAR: begin
                      pg_kind <= PK_CLEAR;
                      state   <= DS_ARMED;
                    end
                    default: begin
                      pg_kind <= PK_FILL;
                      state   <= DS_DATA;
                    end
                  endcase
                end
              endcase
            end
          end
          DS_DATA: begin
            pg_data <= {pg_data[DATA_W-2:0], di};
            cnt     <= cnt + 1'b1;
            if (last_dat) state <= DS_ARMED;
          end
          DS_READ: begin
            rd_bit <= sh[DATA_W-1];
            sh     <= {sh[DATA_W-2:0], 1'b0};
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uwe_prog.sv
module uwe_prog
  import uwe_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  pg_kind_e          kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              wen_set,
  input  logic              wen_clr,
  output logic              busy,
  output logic              wen,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int BC_W = $clog2(BUSY_CYCLES + 1);

  logic              sweeping;
  logic [ADDR_W-1:0] sw_addr;
  logic [DATA_W-1:0] fill;
  logic [BC_W-1:0]   cnt;
  logic              all_words, erase_kind;
  logic [DATA_W-1:0] value;

  assign all_words  = (kind == PK_FILL) || (kind == PK_CLEAR);
  assign erase_kind = (kind == PK_ERASE) || (kind == PK_CLEAR);
  assign value      = erase_kind ? '1 : data;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      wen      <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      sweeping <= 1'b0;
      sw_addr  <= '0;
      fill     <= '0;
      cnt      <= '0;
    end else begin
      wr_en <= 1'b0;
      if (wen_set)      wen <= 1'b1;
      else if (wen_clr) wen <= 1'b0;

      if (go && wen && !busy) begin
        busy <= 1'b1;
        cnt  <= BC_W'(BUSY_CYCLES);
        fill <= value;
        if (all_words) begin
          sweeping <= 1'b1;
          sw_addr  <= '0;
        end else begin
          wr_en   <= 1'b1;
          wr_addr <= addr;
          wr_data <= value;
        end
      end else if (sweeping) begin
        wr_en   <= 1'b1;
        wr_addr <= sw_addr;
        wr_data <= fill;
        sw_addr <= sw_addr + 1'b1;
        if (sw_addr == '1) sweeping <= 1'b0;
      end else if (busy) begin
        if (cnt <= BC_W'(1)) busy <= 1'b0;
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
  import uwe_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);
  logic cs_q, sk_q, sk_d, di_q, sk_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
      sk_d <= 1'b0;
      di_q <= 1'b0;
    end else begin
      cs_q <= cs;
      sk_q <= sk;
      sk_d <= sk_q;
      di_q <= di;
    end
  end
  assign sk_rise = sk_q & ~sk_d;

  logic [ADDR_W-1:0] rd_addr, pg_addr, wr_addr;
  logic [DATA_W-1:0] rd_q, pg_data, wr_data;
  logic              wen_set, wen_clr, pg_go, rd_bit, dec_idle, reading;
  logic              busy, wen, wr_en;
  pg_kind_e          pg_kind;

  uwe_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst(rst), .cs(cs_q), .sk_rise(sk_rise), .di(di_q),
    .busy(busy), .rd_q(rd_q), .rd_addr(rd_addr), .wen_set(wen_set),
    .wen_clr(wen_clr), .pg_go(pg_go), .pg_kind(pg_kind),
    .pg_addr(pg_addr), .pg_data(pg_data), .rd_bit(rd_bit),
    .idle(dec_idle), .reading(reading)
  );

  uwe_prog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .go(pg_go), .kind(pg_kind), .addr(pg_addr),
    .data(pg_data), .wen_set(wen_set), .wen_clr(wen_clr), .busy(busy),
    .wen(wen), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  uwe_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(wr_en), .wa(wr_addr), .wd(wr_data), .ra(rd_addr), .q(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= 1'b0;
    else     dout <= cs_q & ((reading & rd_bit) | (dec_idle & ~busy));
  end
endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk (
  input logic clk,
  input logic rst,
  input logic cs_q,
  input logic dout,
  input logic busy,
  input logic wen,
  input logic wr_en,
  input logic dec_idle,
  input logic pg_go
);
  // R10
  a_r10_quiet_deselected: assert property (@(posedge clk) disable iff (rst)
    !cs_q |=> !dout);
  // R7
  a_r7_busy_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (cs_q && dec_idle && busy) |=> !dout);
  // R7
  a_r7_ready_reads_one: assert property (@(posedge clk) disable iff (rst)
    (cs_q && dec_idle && !busy) |=> dout);
  // R6
  a_r6_write_needs_enable: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wen && busy));
  // R6
  a_r6_locked_no_busy: assert property (@(posedge clk) disable iff (rst)
    (pg_go && !wen && !busy) |=> !busy);
  // R8
  a_r8_idle_while_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && dec_idle) |=> dec_idle);
endmodule

bind uwire_eeprom uwire_eeprom_chk u_chk (
  .clk(clk), .rst(rst), .cs_q(cs_q), .dout(dout), .busy(busy), .wen(wen),
  .wr_en(wr_en), .dec_idle(dec_idle), .pg_go(pg_go)
);

// File: tb/uwire_eeprom_tb.sv
`timescale 1ns/1ps
module uwire_eeprom_tb;
  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int BUSY  = 300;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout;
  int n_tests = 0, n_fail = 0;
  logic [DW-1:0] model [DEPTH];

  always #2.5 clk = ~clk;

  uwire_eeprom #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .dout(dout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    di = b; tick(4); sk = 1'b1; tick(4); sk = 1'b0;
  endtask

  task automatic cs_up();   cs = 1'b1; tick(4); endtask
  task automatic cs_down(); cs = 1'b0; di = 1'b0; tick(6); endtask

  task automatic hdr(input logic [1:0] op, input logic [AW-1:0] a);
    send_bit(1'b1); send_bit(op[1]); send_bit(op[0]);
    for (int i = AW - 1; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic send_word(input logic [DW-1:0] d, input int nbits);
    for (int i = DW - 1; i >= DW - nbits; i--) send_bit(d[i]);
  endtask

  task automatic read_word(input logic [AW-1:0] a, input int pre,
                           output logic [DW-1:0] d, output logic lead);
    cs_up();
    for (int i = 0; i < pre; i++) send_bit(1'b0);
    hdr(2'b10, a);
    lead = dout;
    for (int i = DW - 1; i >= 0; i--) begin
      send_bit(1'b0);
      d[i] = dout;
    end
    cs_down();
  endtask

  task automatic wait_ready(output int cyc, output logic first);
    cs_up();
    first = dout;
    cyc = 0;
    while (dout !== 1'b1 && cyc < 5000) begin tick(1); cyc++; end
    cs_down();
  endtask

  task automatic special(input logic [1:0] sub);
    cs_up(); hdr(2'b00, {sub, {(AW-2){1'b0}}}); cs_down();
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cs_up(); hdr(2'b01, a); send_word(d, DW); cs_down();
  endtask

  task automatic verify_all(input string req);
    logic [DW-1:0] d; logic lead;
    for (int a = 0; a < DEPTH; a++) begin
      read_word(AW'(a), 0, d, lead);
      check(d === model[a], req, d, model[a]);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    report();
    $finish;
  end

  initial begin
    int c; logic f, lead; logic [DW-1:0] d, v;
    tick(5); rst = 1'b0; tick(3);
    check(dout === 1'b0, "R10 reset, cs low", dout, 0);
    cs_up();
    check(dout === 1'b1, "R7 idle ready", dout, 1);
    cs_down();
    check(dout === 1'b0, "R10 after deselect", dout, 0);

    // R6: locked after reset
    write_word(6'd5, 16'h1234);
    wait_ready(c, f);
    check(f === 1'b1, "R6 locked write starts no busy", f, 1);
    special(2'b10);
    wait_ready(c, f);
    check(f === 1'b1, "R6 locked clear starts no busy", f, 1);

    // R5 clear-all after unlock
    special(2'b11);
    special(2'b10);
    wait_ready(c, f);
    check(f === 1'b0, "R7 busy after clear-all", f, 0);
    check(c >= BUSY + DEPTH - 16 && c <= BUSY + DEPTH, "R7 clear-all busy length", c, BUSY + DEPTH);
    for (int a = 0; a < DEPTH; a++) model[a] = '1;
    verify_all("R5 clear-all value");

    // R3 writes across the array
    for (int a = 0; a < DEPTH; a++) begin
      v = DW'(a * 16'h0101) ^ 16'h5A3C;
      write_word(AW'(a), v);
      model[a] = v;
      wait_ready(c, f);
      if (a == 0) begin
        check(f === 1'b0, "R7 busy after write", f, 0);
        check(c >= BUSY - 16 && c <= BUSY, "R7 write busy length", c, BUSY);
      end
    end
    verify_all("R3 write readback");

    // R2 leading zero
    read_word(6'd9, 0, d, lead);
    check(lead === 1'b0, "R2 leading zero", lead, 0);
    check(d === model[9], "R2 read data", d, model[9]);

    // R1 zeros before start bit
    read_word(6'd33, 3, d, lead);
    check(d === model[33], "R1 zeros before start ignored", d, model[33]);

    // R4 erase one word
    cs_up(); hdr(2'b11, 6'd7); cs_down();
    wait_ready(c, f);
    check(f === 1'b0, "R4 erase busy", f, 0);
    model[7] = '1;
    read_word(6'd7, 0, d, lead);
    check(d === 16'hFFFF, "R4 erased word", d, 16'hFFFF);
    read_word(6'd8, 0, d, lead);
    check(d === model[8], "R4 neighbour kept", d, model[8]);

    // R9 abort mid-data
    cs_up(); hdr(2'b01, 6'd3); send_word(16'h0F0F, 8); cs_down();
    wait_ready(c, f);
    check(f === 1'b1, "R9 aborted write starts no busy", f, 1);
    read_word(6'd3, 0, d, lead);
    check(d === model[3], "R9 aborted write no change", d, model[3]);

    // R8 instruction during busy is ignored
    write_word(6'd10, 16'hBEEF);
    model[10] = 16'hBEEF;
    cs_up(); hdr(2'b11, 6'd10); cs_down();
    wait_ready(c, f);
    check(f === 1'b0, "R8 still busy after ignored erase", f, 0);
    read_word(6'd10, 0, d, lead);
    check(d === 16'hBEEF, "R8 erase during busy ignored", d, 16'hBEEF);

    // R5 fill-all
    cs_up(); hdr(2'b00, {2'b01, {(AW-2){1'b0}}}); send_word(16'hC3A5, DW); cs_down();
    wait_ready(c, f);
    check(f === 1'b0, "R5 fill busy", f, 0);
    for (int a = 0; a < DEPTH; a++) model[a] = 16'hC3A5;
    verify_all("R5 fill-all value");

    // R6 lock again
    special(2'b00);
    write_word(6'd0, 16'h1111);
    wait_ready(c, f);
    check(f === 1'b1, "R6 relocked write no busy", f, 1);
    read_word(6'd0, 0, d, lead);
    check(d === model[0], "R6 relocked write no change", d, model[0]);
    cs_up(); hdr(2'b11, 6'd1); cs_down();
    wait_ready(c, f);
    read_word(6'd1, 0, d, lead);
    check(d === model[1], "R6 relocked erase no change", d, model[1]);

    check(dout === 1'b0, "R10 final deselected", dout, 0);
    report();
    $finish;
  end
endmodule